// File: doc/BRIEF.md
# Prescaled Byte-Bus Timer with Snapshot Capture

This peripheral keeps a free-running up-counter that advances once per programmable number of clock cycles, and exposes it over a narrow byte bus with no handshake. The bus carries a 3-bit offset, an 8-bit write byte, a write strobe and an 8-bit read byte. The read byte is a combinational function of the offset and the registered state.

Software reads the count through a snapshot register. A write to the capture offset copies the live count into the snapshot. The four snapshot bytes can then be read in any order without tearing, because the snapshot holds still while the counter keeps running. A write to a separate clear offset returns both the counter and the prescale divider to zero. The 16-bit prescale value sits at two writable offsets.

Top module: `snap_timer`

## Requirements
- R1: After reset the counter, the divider, the snapshot and the prescale value are all zero, so every offset 0..7 reads 0x00.
- R2: Reads at offsets 0, 1, 2 and 3 return snapshot bits [7:0], [15:8], [23:16] and [31:24] respectively. Snapshot bits above the counter width read as zero.
- R3: A write of any byte to offset 4 sets the counter and the prescale divider to zero at that clock edge. The count then stays at zero through the next P clock edges.
- R4: A write of any byte to offset 5 loads the snapshot with the counter value present in the cycle of the write, which is the value before that edge's increment.
- R5: Offset 6 holds prescale bits [7:0] and offset 7 holds bits [15:8]. Each is written by a byte write to its offset and reads back the last byte written.
- R6: With a prescale value P, the counter increments on every (P+1)-th clock edge after a clear. P = 0 increments on every edge. A newly written P applies from the following cycle. If the divider already meets or exceeds the new P, the counter increments at the next edge.
- R7: Offsets 4 and 5 always read 0x00. Writes to offsets 0..3 change nothing: the snapshot, the counter and the prescale value are unaffected.
- R8: The counter wraps from its all-ones value (0xFFFFFFFF at the default 32-bit width) to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset within the peripheral |
| bus_wdata | input | 8 | Byte to write |
| bus_we | input | 1 | Write strobe, one byte write per cycle while high |
| bus_rdata | output | 8 | Byte at bus_addr, combinational |

## Verification
Because the live count is never visible directly, most internal faults show up only after a capture. The bench therefore captures and reads back often. A wrong divider compare or a counter step that is missed or doubled makes the snapshot bytes drift from the reference by one or more counts, and this is seen at the first capture after the fault. A faulty capture or clear decode shows up on the very next read of offsets 0..3. A prescale register fault shows up on the read of offset 6 or 7 in the same cycle. A narrow second instance makes the wrap happen within about a thousand cycles, so a missing or wrong wrap becomes visible soon after.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;

  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int PRE_W   = 16;
  localparam int PRE_BYTES = PRE_W / DATA_W;

  localparam logic [ADDR_W-1:0] OFF_CLEAR   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_CAPTURE = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_PRE_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_PRE_HI  = 3'd7;

  // divider reached its terminal count (>= so that a lowered prescale never stalls)
  function automatic logic tick_due(input logic [PRE_W-1:0] div, input logic [PRE_W-1:0] pre);
    return div >= pre;
  endfunction

  function automatic logic [PRE_W-1:0] div_step(input logic [PRE_W-1:0] div, input logic [PRE_W-1:0] pre);
    return tick_due(div, pre) ? '0 : div + 16'd1;
  endfunction

  function automatic logic [DATA_W-1:0] pick_byte(input logic [31:0] v, input logic [1:0] idx);
    return v[idx*8 +: 8];
  endfunction

endpackage

// File: rtl/snap_timer_div.sv
module snap_timer_div
  import snap_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] presc,
  output logic             tick,
  output logic [PRE_W-1:0] div_q
);

  assign tick = !clr && tick_due(div_q, presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= div_step(div_q, presc);
  end

endmodule

// File: rtl/snap_timer_cnt.sv
module snap_timer_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/snap_timer_regs.sv
module snap_timer_regs
  import snap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRE_BYTES-1:0] pre_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 cap,
  input  logic [CNT_W-1:0]     cnt,
  output logic [PRE_W-1:0]     presc_q,
  output logic [CNT_W-1:0]     snap_q
);

  for (genvar g = 0; g < PRE_BYTES; g++) begin : g_pre
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         presc_q[g*DATA_W +: DATA_W] <= '0;
      else if (pre_we[g]) presc_q[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   snap_q <= '0;
    else if (cap) snap_q <= cnt;
  end

endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  output logic [7:0]  bus_rdata
);

  // named internal events, also observed by the bound checker
  logic             clr_evt;
  logic             snap_evt;
  logic             tick_evt;
  logic [PRE_BYTES-1:0] pre_we;
  logic [PRE_W-1:0] presc_q;
  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;
  logic [31:0]      snap_ext;

  assign clr_evt   = bus_we && (bus_addr == OFF_CLEAR);
  assign snap_evt  = bus_we && (bus_addr == OFF_CAPTURE);
  assign pre_we[0] = bus_we && (bus_addr == OFF_PRE_LO);
  assign pre_we[1] = bus_we && (bus_addr == OFF_PRE_HI);

  snap_timer_div u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .presc(presc_q),
    .tick(tick_evt), .div_q(div_q)
  );

  snap_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .tick(tick_evt), .cnt_q(cnt_q)
  );

  snap_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .wdata(bus_wdata),
    .cap(snap_evt), .cnt(cnt_q), .presc_q(presc_q), .snap_q(snap_q)
  );

  if (CNT_W == 32) begin : g_full
    assign snap_ext = snap_q;
  end else begin : g_pad
    assign snap_ext = {{(32-CNT_W){1'b0}}, snap_q};
  end

  always_comb begin
    unique case (bus_addr)
      3'd0, 3'd1, 3'd2, 3'd3: bus_rdata = pick_byte(snap_ext, bus_addr[1:0]);
      OFF_PRE_LO:             bus_rdata = presc_q[7:0];
      OFF_PRE_HI:             bus_rdata = presc_q[15:8];
      default:                bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/snap_timer_chk.sv
module snap_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             clr,
  input logic             snap_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap,
  input logic [15:0]      div,
  input logic [2:0]       addr,
  input logic [7:0]       rdata
);

  AST_CLEAR_CNT: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == '0); // R3
  AST_CLEAR_DIV: assert property (@(posedge clk) disable iff (!rst_n) clr |=> div == '0); // R3
  AST_CAPTURE:   assert property (@(posedge clk) disable iff (!rst_n) snap_wr |=> snap == $past(cnt)); // R4
  AST_STEP_ONE:  assert property (@(posedge clk) disable iff (!rst_n)
                   (tick && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !clr) |=> $stable(cnt)); // R6
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !snap_wr |=> $stable(snap)); // R7
  AST_CMD_READ0: assert property (@(posedge clk) disable iff (!rst_n)
                   (addr == 3'd4 || addr == 3'd5) |-> rdata == 8'h00); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                   (tick && !clr && cnt == '1) |=> cnt == '0); // R8

endmodule

bind snap_timer snap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_evt), .clr(clr_evt), .snap_wr(snap_evt),
  .cnt(cnt_q), .snap(snap_q), .div(div_q), .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/tb_snap_timer.sv
module tb_snap_timer;

  localparam time CLK_PERIOD = 10ns;
  localparam int  SMALL_W = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] rd_main, rd_small;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rd_main)
  );

  snap_timer #(.CNT_W(SMALL_W)) dut_small (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rd_small)
  );

  // behavioural reference: plain integers, index 0 = 32-bit, 1 = narrow instance
  longint unsigned m_cnt[2], m_snap[2], m_mask[2];
  longint unsigned m_div, m_pre;

  initial begin
    m_mask[0] = 64'hFFFF_FFFF;
    m_mask[1] = (64'd1 << SMALL_W) - 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '{0, 0}; m_snap = '{0, 0}; m_div = 0; m_pre = 0;
    end else begin
      bit clr, cap, adv;
      clr = bus_we && bus_addr == 3'd4;
      cap = bus_we && bus_addr == 3'd5;
      adv = !clr && (m_div >= m_pre);
      for (int k = 0; k < 2; k++) begin
        if (cap) m_snap[k] = m_cnt[k];
        if (clr) m_cnt[k] = 0;
        else if (adv) m_cnt[k] = (m_cnt[k] + 1) & m_mask[k];
      end
      if (clr || adv) m_div = 0; else m_div = m_div + 1;
      if (bus_we && bus_addr == 3'd6) m_pre = (m_pre & 64'hFF00) | bus_wdata;
      if (bus_we && bus_addr == 3'd7) m_pre = (m_pre & 64'h00FF) | (longint'(bus_wdata) << 8);
    end
  end

  function automatic int exp_byte(int k, int a);
    if (a < 4)  return int'((m_snap[k] >> (8*a)) & 8'hFF);
    if (a == 6) return int'(m_pre & 8'hFF);
    if (a == 7) return int'((m_pre >> 8) & 8'hFF);
    return 0;
  endfunction

  function automatic string req_of(int a);
    if (a < 4) return "R2";
    if (a < 6) return "R7";
    return "R5";
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h t=%0t", req, bus_addr, got, exp, $time);
    end
  endtask

  // one cycle: compare both instances at the negedge, against the reference
  task automatic cyc();
    @(negedge clk);
    check({cur_req, "/", req_of(int'(bus_addr)), " main"}, int'(rd_main), exp_byte(0, int'(bus_addr)));
    check({cur_req, "/", req_of(int'(bus_addr)), " small"}, int'(rd_small), exp_byte(1, int'(bus_addr)));
  endtask

  task automatic wr(int a, int d);
    cyc();
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd_all();
    for (int i = 0; i < 8; i++) begin
      cyc();
      bus_addr = 3'(i);
    end
    cyc();
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1-run actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: explicit reset state, every offset reads zero
    for (int i = 0; i < 8; i++) begin
      bus_addr = 3'(i);
      #1;
      check("R1 reset main", int'(rd_main), 0);
      check("R1 reset small", int'(rd_small), 0);
    end
    rst_n = 1'b1;
    cur_req = "R1"; idle(4); rd_all();

    // R5 prescale write / readback, R6 divided counting
    cur_req = "R5"; wr(6, 8'h03); wr(7, 8'h00); rd_all();
    cur_req = "R3"; wr(4, 8'h5A); idle(2); wr(5, 0); rd_all();
    cur_req = "R6"; idle(37); wr(5, 8'hFF); rd_all();

    // R4 capture at several points; R7 writes to snapshot offsets are ignored
    cur_req = "R4"; idle(5); wr(5, 1); idle(13); rd_all();
    cur_req = "R7"; wr(0, 8'hAA); wr(1, 8'h55); wr(2, 8'hFF); wr(3, 8'h11); rd_all();
    wr(5, 0); rd_all();

    // R6 prescale zero counts every clock
    cur_req = "R6"; wr(6, 0); wr(4, 0); idle(20); wr(5, 0); rd_all();
    // R6 larger prescale in both bytes, then lowered below the divider
    cur_req = "R5"; wr(7, 8'h01); wr(6, 8'h02); rd_all();
    cur_req = "R6"; wr(4, 0); idle(700); wr(5, 0); rd_all();
    idle(100); wr(7, 0); wr(6, 8'h04); idle(30); wr(5, 0); rd_all();

    // R8 wrap of the narrow instance
    cur_req = "R8"; wr(6, 0); wr(4, 0); idle((1 << SMALL_W) - 6);
    for (int j = 0; j < 10; j++) begin
      wr(5, 0); cyc(); bus_addr = 3'd0; cyc(); bus_addr = 3'd1; cyc();
    end
    idle(1500); wr(5, 0); rd_all();

    // R3 clear while counting, immediately captured
    cur_req = "R3"; wr(4, 0); wr(5, 0); rd_all();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule